// File: doc/BRIEF.md
# Floating-Point Load Widener (single/double to 80-bit extended)

This block turns a 32-bit or 64-bit binary floating-point operand into the 80-bit extended format that a floating-point unit keeps in its register stack. A one-bit select picks the source format. The block pulls out the sign, exponent and fraction. It sorts the value into one of five classes, rebiases the exponent to the 15-bit extended bias of 16383, and writes the integer bit out explicitly at bit 63. The fraction sits left-aligned below the integer bit.

A source denormal is not copied across as a denormal. Its leading one is found with a leading-zero count and shifted up to bit 63, and the exponent is lowered by the same shift. Every finite nonzero source therefore becomes a normalized extended value. Infinities and NaNs keep their sign. A NaN keeps its payload, left-aligned, so it stays a NaN.

The result, the class code and a valid strobe are registered once. They appear on the clock edge after the operand is presented and hold until the next accepted operand.

Top module: `fp_widen80`

## Requirements
- R1: With `fmt`=0, a single-precision normal (exponent field E in 1..254, fraction F, held in `din[31:0]`) gives `dout` = {sign, E+16256 (15 bits), 1, F, 40 zero bits}. 1.0 (3F800000h) gives 3FFF8000000000000000h.
- R2: With `fmt`=1, a double-precision normal (E in 1..2046) gives `dout` = {sign, E+15360, 1, F, 11 zero bits}. 1.0 (3FF0000000000000h) gives 3FFF8000000000000000h.
- R3: A zero source (E=0, F=0) gives `dout` = {source sign, 79 zero bits}, so +0 and -0 both survive.
- R4: A denormal source (E=0, F≠0) is shifted left by n places until its leading one reaches bit 63. The exponent field becomes 16257-n for single and 15361-n for double. The smallest single denormal (00000001h) gives 3F6A8000000000000000h.
- R5: An infinity source (E all ones, F=0) gives exponent 7FFFh, bit 63 set, bits 62..0 zero, and the source sign.
- R6: A NaN source (E all ones, F≠0) gives exponent 7FFFh, bit 63 set, the source fraction left-aligned from bit 62 down, and the source sign.
- R7: `cls` reports 0 for zero, 1 for denormal, 2 for normal, 3 for infinity and 4 for NaN.
- R8: With `fmt`=0, `din[63:32]` has no effect on `dout` or `cls`.
- R9: `out_valid` equals `in_valid` one clock earlier. `dout` and `cls` take the new result one clock after an operand with `in_valid`=1 and hold while `in_valid` is 0.
- R10: While `rst_n` is low, `out_valid`, `dout` and `cls` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand on `din` is to be converted |
| fmt | input | 1 | Source format: 0 single (low 32 bits), 1 double |
| din | input | 64 | Source operand |
| out_valid | output | 1 | `dout`/`cls` hold a fresh result this cycle |
| dout | output | 80 | Extended result: sign 79, exponent 78..64, integer bit 63, fraction 62..0 |
| cls | output | 3 | Class of the converted operand |

## Verification
Positive and negative ones in both formats expose errors in the two rebias constants and in sign routing. Signed zeros, the smallest and largest denormals of each width, infinities, and quiet and signalling-style NaNs each exercise a separate class path. The two denormal extremes in particular test the leading-zero count and the exponent correction at both ends of the shift range. Single operands with garbage in the upper word show whether the format select isolates the unused half. A long run of random operands, biased toward an all-zero or all-one exponent, with idle cycles mixed in, is compared every clock against a behavioural model that normalizes by repeated doubling, which also checks the hold behaviour between operands.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
   localparam int XEW   = 15;
   localparam int XMW   = 64;
   localparam int XW    = 1 + XEW + XMW;
   localparam int XBIAS = (1 << (XEW - 1)) - 1;

   typedef enum logic [2:0] {
      FC_ZERO = 3'd0,
      FC_SUB  = 3'd1,
      FC_NORM = 3'd2,
      FC_INF  = 3'd3,
      FC_NAN  = 3'd4
   } fclass_e;

   typedef struct packed {
      logic           sign;
      fclass_e        cls;
      logic [XEW-1:0] exp;
      logic [XMW-1:0] man;
   } unpacked_t;
endpackage

// File: rtl/fpw_unpack.sv
module fpw_unpack
   import fpw_pkg::*;
#(
   parameter int EW = 8,
   parameter int FW = 23
) (
   input  logic [EW+FW:0] op,
   output unpacked_t      u
);
   localparam int BIAS = (1 << (EW - 1)) - 1;
   localparam int PAD  = XMW - 1 - FW;
   localparam logic [XEW-1:0] NORM_OFS = XEW'(XBIAS - BIAS);
   localparam logic [XEW-1:0] SUB_EXP  = XEW'(XBIAS - BIAS + 1);

   generate
      if (PAD < 1 || EW >= XEW || EW < 2) begin : g_bad_fmt
         $error("fpw_unpack: source format does not fit the extended format");
      end
   endgenerate

   logic [EW-1:0] e;
   logic [FW-1:0] f;
   assign e = op[EW+FW-1:FW];
   assign f = op[FW-1:0];

   always_comb begin
      u.sign = op[EW+FW];
      u.man  = {1'b1, f, {PAD{1'b0}}};
      u.exp  = {{(XEW-EW){1'b0}}, e} + NORM_OFS;
      u.cls  = FC_NORM;
      if (e == '0) begin
         u.man[XMW-1] = 1'b0;
         if (f == '0) begin
            u.cls = FC_ZERO;
            u.exp = '0;
         end else begin
            u.cls = FC_SUB;
            u.exp = SUB_EXP;
         end
      end else if (&e) begin
         u.exp = '1;
         u.cls = (f == '0) ? FC_INF : FC_NAN;
      end
   end
endmodule

// File: rtl/fpw_lzc.sv
module fpw_lzc #(
   parameter int W  = 64,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  v,
   output logic [CW-1:0] cnt
);
   generate
      if (W < 2) begin : g_bad_w
         $error("fpw_lzc: width too small");
      end
   endgenerate

   always_comb begin
      cnt = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (v[i]) cnt = CW'(W - 1 - i);
      end
   end
endmodule

// File: rtl/fpw_norm.sv
module fpw_norm
   import fpw_pkg::*;
(
   input  unpacked_t      u,
   output logic [XW-1:0]  word
);
   localparam int LZW = $clog2(XMW + 1);

   logic [LZW-1:0] lz;
   logic [XMW-1:0] shifted;
   logic [XEW-1:0] exp_adj;

   fpw_lzc #(.W(XMW), .CW(LZW)) u_lzc (
      .v   (u.man),
      .cnt (lz)
   );

   assign shifted = u.man << lz;
   assign exp_adj = u.exp - {{(XEW-LZW){1'b0}}, lz};

   always_comb begin
      if (u.cls == FC_SUB) word = {u.sign, exp_adj, shifted};
      else                 word = {u.sign, u.exp, u.man};
   end
endmodule

// File: rtl/fp_widen80.sv
module fp_widen80
   import fpw_pkg::*;
#(
   parameter int SP_EW = 8,
   parameter int SP_FW = 23,
   parameter int DP_EW = 11,
   parameter int DP_FW = 52,
   parameter int DIN_W = DP_EW + DP_FW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             fmt,
   input  logic [DIN_W-1:0] din,
   output logic             out_valid,
   output logic [XW-1:0]    dout,
   output logic [2:0]       cls
);
   localparam int SP_W = SP_EW + SP_FW + 1;

   generate
      if (SP_W > DIN_W || DP_EW + DP_FW + 1 != DIN_W) begin : g_bad_din
         $error("fp_widen80: operand widths inconsistent with din");
      end
   endgenerate

   unpacked_t up [2];
   unpacked_t sel;
   logic [XW-1:0] word;

   for (genvar g = 0; g < 2; g++) begin : g_fmt
      localparam int EWG = (g == 0) ? SP_EW : DP_EW;
      localparam int FWG = (g == 0) ? SP_FW : DP_FW;
      fpw_unpack #(.EW(EWG), .FW(FWG)) u_unpack (
         .op (din[EWG+FWG:0]),
         .u  (up[g])
      );
   end

   assign sel = fmt ? up[1] : up[0];

   fpw_norm u_norm (
      .u    (sel),
      .word (word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         dout      <= '0;
         cls       <= 3'd0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            dout <= word;
            cls  <= sel.cls;
         end
      end
   end
endmodule

// File: rtl/fp_widen80_chk.sv
module fp_widen80_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        out_valid,
   input logic [79:0] dout,
   input logic [2:0]  cls
);
   assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(dout) && $stable(cls)));
   assert_class_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cls <= 3'd4);
   assert_zero_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cls == 3'd0) |-> dout[78:0] == 79'd0);
   assert_denorm_norm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cls == 3'd1) |-> (dout[63] && dout[78:64] != 15'h7fff && dout[78:64] != 15'd0));
   assert_inf_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cls == 3'd3) |-> (dout[78:63] == 16'hffff && dout[62:0] == 63'd0));
   assert_nan_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cls == 3'd4) |-> (dout[78:63] == 16'hffff && dout[62:0] != 63'd0));
   assert_normal_int_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cls == 3'd2) |-> (dout[63] && dout[78:64] != 15'h7fff));
endmodule

bind fp_widen80 fp_widen80_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .dout      (dout),
   .cls       (cls)
);

// File: tb/fp_widen80_test.sv
`timescale 1ns/1ps
module fp_widen80_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        fmt = 1'b0;
   logic [63:0] din = 64'd0;
   logic        out_valid;
   logic [79:0] dout;
   logic [2:0]  cls;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   string cur_tag = "R10";
   string tag_q = "R10";

   logic        m_valid = 1'b0;
   logic [79:0] m_dout = 80'd0;
   logic [2:0]  m_cls = 3'd0;

   always #10 clk = ~clk;

   fp_widen80 uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt),
      .din(din), .out_valid(out_valid), .dout(dout), .cls(cls)
   );

   // behavioural reference: returns {class, 80-bit word}
   function automatic logic [82:0] ref_widen(input logic f, input logic [63:0] d);
      int ew, fw, bias, x;
      logic s;
      logic [2:0] c;
      logic [63:0] e, fr, m, mant;
      logic [14:0] xe;
      if (!f) begin ew = 8;  fw = 23; bias = 127;  s = d[31]; end
      else    begin ew = 11; fw = 52; bias = 1023; s = d[63]; end
      e  = (d >> fw) & ((64'd1 << ew) - 64'd1);
      fr = d & ((64'd1 << fw) - 64'd1);
      if (e == 64'd0 && fr == 64'd0) return {3'd0, s, 79'd0};
      if (e == (64'd1 << ew) - 64'd1) begin
         mant = 64'h8000_0000_0000_0000 | (fr << (63 - fw));
         c = (fr == 64'd0) ? 3'd3 : 3'd4;
         return {c, s, 15'h7fff, mant};
      end
      if (e == 64'd0) begin
         m = fr;
         x = 1 - bias;
         while (((m >> fw) & 64'd1) == 64'd0) begin
            m = m << 1;
            x = x - 1;
         end
         c = 3'd1;
      end else begin
         m = fr | (64'd1 << fw);
         x = int'(e) - bias;
         c = 3'd2;
      end
      xe = 15'(x + 16383);
      mant = m << (63 - fw);
      return {c, s, xe, mant};
   endfunction

   // cycle model
   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid <= 1'b0;
         m_dout  <= 80'd0;
         m_cls   <= 3'd0;
      end else begin
         m_valid <= in_valid;
         if (in_valid) {m_cls, m_dout} <= ref_widen(fmt, din);
      end
      tag_q <= cur_tag;
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (!finished) begin
         n_run++;
         if (out_valid !== m_valid || dout !== m_dout || cls !== m_cls) begin
            n_fail++;
            $display("FAIL %s (R9 timing): got v=%0b d=%h c=%0d expected v=%0b d=%h c=%0d",
                     tag_q, out_valid, dout, cls, m_valid, m_dout, m_cls);
         end
      end
   end

   task automatic chk_lit(input string tag, input logic [79:0] exp_d, input logic [2:0] exp_c);
      n_run++;
      if (dout !== exp_d || cls !== exp_c) begin
         n_fail++;
         $display("FAIL %s: got d=%h c=%0d expected d=%h c=%0d", tag, dout, cls, exp_d, exp_c);
      end
   endtask

   task automatic drive(input string tag, input logic f, input logic [63:0] d);
      @(negedge clk);
      cur_tag  = tag;
      in_valid = 1'b1;
      fmt      = f;
      din      = d;
      @(negedge clk);
      in_valid = 1'b0;
      din      = ~d;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      n_run++;   // R10 reset state
      if (out_valid !== 1'b0 || dout !== 80'd0 || cls !== 3'd0) begin
         n_fail++;
         $display("FAIL R10: got v=%0b d=%h c=%0d expected 0 0 0", out_valid, dout, cls);
      end
      rst_n = 1'b1;

      drive("R1", 1'b0, 64'h0000_0000_3F80_0000);
      chk_lit("R1 one single", 80'h3FFF_8000_0000_0000_0000, 3'd2);
      drive("R2", 1'b1, 64'h3FF0_0000_0000_0000);
      chk_lit("R2 one double", 80'h3FFF_8000_0000_0000_0000, 3'd2);
      drive("R1", 1'b0, 64'h0000_0000_4189_3333);
      drive("R1", 1'b0, 64'h0000_0000_C2A7_6666);
      drive("R2", 1'b1, 64'hC00C_0000_0000_0001);
      drive("R3", 1'b0, 64'h0000_0000_8000_0000);
      chk_lit("R3 neg zero single", {1'b1, 79'd0}, 3'd0);
      drive("R3", 1'b1, 64'h0000_0000_0000_0000);
      drive("R3", 1'b1, 64'h8000_0000_0000_0000);
      drive("R4", 1'b0, 64'h0000_0000_0000_0001);
      chk_lit("R4 min single denormal", 80'h3F6A_8000_0000_0000_0000, 3'd1);
      drive("R4", 1'b0, 64'h0000_0000_807F_FFFF);
      drive("R4", 1'b1, 64'h0000_0000_0000_0001);
      drive("R4", 1'b1, 64'h800F_FFFF_FFFF_FFFF);
      drive("R5", 1'b0, 64'h0000_0000_7F80_0000);
      chk_lit("R5 pos inf single", 80'h7FFF_8000_0000_0000_0000, 3'd3);
      drive("R5", 1'b1, 64'hFFF0_0000_0000_0000);
      drive("R6", 1'b0, 64'h0000_0000_7FC0_0000);
      chk_lit("R6 quiet nan single", 80'h7FFF_C000_0000_0000_0000, 3'd4);
      drive("R6", 1'b0, 64'h0000_0000_FF80_0001);
      drive("R6", 1'b1, 64'h7FF0_0000_0000_0001);
      drive("R7", 1'b1, 64'h7FEF_FFFF_FFFF_FFFF);
      drive("R8", 1'b0, 64'hDEAD_BEEF_3F80_0000);
      chk_lit("R8 upper ignored", 80'h3FFF_8000_0000_0000_0000, 3'd2);
      drive("R8", 1'b0, 64'hFFFF_FFFF_0000_0000);
      chk_lit("R8 upper ignored zero", 80'd0, 3'd0);

      // R9 hold across idle cycles with changing din
      @(negedge clk);
      cur_tag = "R9";
      din = 64'h1234_5678_9ABC_DEF0;
      repeat (3) @(negedge clk);

      // random mix, R7 classes in both formats
      for (int k = 0; k < 600; k++) begin
         logic [63:0] r;
         logic f;
         r = {$urandom, $urandom};
         f = 1'($urandom_range(0, 1));
         case ($urandom_range(0, 3))
            0: if (f) r[62:52] = 11'd0; else r[30:23] = 8'd0;
            1: if (f) r[62:52] = 11'h7ff; else r[30:23] = 8'hff;
            default: ;
         endcase
         @(negedge clk);
         cur_tag  = "R7";
         in_valid = ($urandom_range(0, 4) != 0);
         fmt      = f;
         din      = r;
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!finished) begin
         finished = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule